// File: doc/BRIEF.md
# Pipelined Modular Butterfly for a Number-Theoretic Transform

This block performs one radix-2 decimation-in-time butterfly over the prime field of order q (default 3329) on every clock cycle. A caller presents two reduced coefficients, `uIn` and `vIn`, together with a twiddle factor `wIn` and a valid strobe. A fixed number of cycles later the block returns the sum output `xOut = (u + v·w) mod q` and the difference output `yOut = (u − v·w) mod q`. A matching valid strobe comes out with them.

The product v·w is formed with Montgomery arithmetic and a radix R = 2^16. The caller therefore supplies each twiddle already scaled into Montgomery form, `wIn = (w·2^16) mod q`, so the reduced product equals the plain field product v·w mod q. The Montgomery constant −q⁻¹ mod R is derived at elaboration from the modulus parameter.

The work is split into three pipeline phases: an operand buffer, then the multiply with Montgomery reduction, then the modular add and subtract. A small control module tracks which phases hold live data. Address generation, coefficient and twiddle storage, and the final scaling of an inverse transform all belong to the surrounding engine.

Top module: `ntt_butterfly`

## Requirements
- R1: When `validOut` is high, `xOut` equals (u + v·w) mod q. Here u and v are the coefficients and `wIn` = (w·65536) mod q is the Montgomery-form twiddle, all taken from the same input beat.
- R2: When `validOut` is high, `yOut` equals (u − v·w) mod q for the same beat. A negative difference wraps by adding q.
- R3: Whenever `validOut` is high, both `xOut` and `yOut` lie in the range [0, q−1].
- R4: The latency is exactly 3 clock cycles. `validOut` equals `validIn` sampled three rising edges earlier, and the data belonging to that beat is presented at the same time.
- R5: A new beat is accepted on every cycle. Back-to-back beats and beats separated by idle cycles each appear at the output in their input order, and idle cycles reproduce as low `validOut` cycles.
- R6: A synchronous reset (`rst` high at a rising edge) clears every in-flight valid bit and sets `xOut` and `yOut` to 0. Beats in flight at the reset never appear at the output.
- R7: Edge operands are reduced correctly. These are u, v or w equal to 0 or q−1, sums that reach or exceed q, and differences below zero.
- R8: While `validOut` is low, `xOut` and `yOut` hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| validIn | input | 1 | Marks a live input beat |
| uIn | input | 12 | Coefficient u, reduced mod q |
| vIn | input | 12 | Coefficient v, reduced mod q |
| wIn | input | 12 | Twiddle in Montgomery form, (w·2^16) mod q |
| validOut | output | 1 | Marks a live result beat |
| xOut | output | 12 | (u + v·w) mod q |
| yOut | output | 12 | (u − v·w) mod q |

## Verification
A table of hand-worked beats is streamed back to back. Its entries isolate the zero product, the wrap of the sum at exactly q and above it, the wrap of a negative difference, and the (q−1)·(q−1) product that separates a correct Montgomery correction step from a missing one. A few hundred random beats with plain twiddles converted to Montgomery form expose wrong reduction constants or carries that the small table cannot reach. A stream with idle bubbles tells correct valid alignment apart from a pipeline that drops or shifts beats. A reset in the middle of a stream shows whether in-flight beats are discarded and whether the outputs hold their values during idle cycles.

// File: rtl/ntt_bfly_pkg.sv
package ntt_bfly_pkg;

  // Strobes from the phase tracker to the arithmetic datapath.
  typedef struct packed {
    logic ldBuf;   // capture operands into the buffer phase
    logic ldMul;   // capture Montgomery product and carried u
    logic ldSum;   // capture the sum and difference results
  } phaseStrobes_t;

  localparam int unsigned PIPE_DEPTH = 3;

  // -q^-1 mod 2^logR, by Newton iteration on the inverse of an odd modulus.
  function automatic logic [31:0] negInvModPow2(input int unsigned q, input int unsigned logR);
    logic [31:0] inv;
    logic [31:0] mask;
    logic [31:0] qv;
    mask = (logR >= 32) ? 32'hFFFF_FFFF : ((32'd1 << logR) - 32'd1);
    qv   = q;
    inv  = qv;
    for (int k = 0; k < 5; k++) begin
      inv = inv * (32'd2 - qv * inv);
    end
    return (32'd0 - inv) & mask;
  endfunction

endpackage

// File: rtl/bfly_ctrl.sv
module bfly_ctrl
  import ntt_bfly_pkg::*;
#(
  parameter int unsigned DEPTH = PIPE_DEPTH
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          validIn,
  output phaseStrobes_t strobes,
  output logic          validOut
);

  logic [DEPTH-1:0] liveBits;

  always_ff @(posedge clk) begin
    if (rst) begin
      liveBits <= '0;
    end else begin
      liveBits <= {liveBits[DEPTH-2:0], validIn};
    end
  end

  always_comb begin
    strobes.ldBuf = validIn;
    strobes.ldMul = liveBits[0];
    strobes.ldSum = liveBits[1];
  end

  assign validOut = liveBits[DEPTH-1];

endmodule

// File: rtl/mont_reduce.sv
module mont_reduce #(
  parameter int unsigned Q     = 3329,
  parameter int unsigned W     = 12,
  parameter int unsigned LOG_R = 16,
  parameter logic [31:0] QNEG  = 32'd3327
) (
  input  logic [2*W-1:0] prodIn,
  output logic [W-1:0]   redOut
);

  localparam int unsigned AW = 2*W + LOG_R + 1;
  localparam logic [AW-1:0]      Q_ACC = AW'(Q);
  localparam logic [LOG_R-1:0]   Q_NEG = QNEG[LOG_R-1:0];
  localparam logic [W:0]         Q_W   = Q[W:0];

  logic [2*LOG_R-1:0] mWide;
  logic [LOG_R-1:0]   mLow;
  logic [AW-1:0]      accSum;
  logic [AW-1:0]      accShift;
  logic [W:0]         partial;
  logic [W:0]         corrected;

  always_comb begin
    mWide     = prodIn[LOG_R-1:0] * Q_NEG;
    mLow      = mWide[LOG_R-1:0];
    accSum    = AW'(prodIn) + AW'(mLow) * Q_ACC;
    accShift  = accSum >> LOG_R;
    partial   = accShift[W:0];
    corrected = (partial >= Q_W) ? (partial - Q_W) : partial;
    redOut    = corrected[W-1:0];
  end

endmodule

// File: rtl/mod_addsub.sv
module mod_addsub #(
  parameter int unsigned Q = 3329,
  parameter int unsigned W = 12
) (
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bIn,
  output logic [W-1:0] sumOut,
  output logic [W-1:0] difOut
);

  localparam logic [W:0] Q_W = Q[W:0];

  logic [W:0] rawSum;
  logic [W:0] fixSum;
  logic [W:0] rawDif;
  logic [W:0] fixDif;

  always_comb begin
    rawSum = {1'b0, aIn} + {1'b0, bIn};
    fixSum = (rawSum >= Q_W) ? (rawSum - Q_W) : rawSum;
    rawDif = {1'b0, aIn} - {1'b0, bIn};
    fixDif = (aIn < bIn) ? (rawDif + Q_W) : rawDif;
    sumOut = fixSum[W-1:0];
    difOut = fixDif[W-1:0];
  end

endmodule

// File: rtl/bfly_datapath.sv
module bfly_datapath
  import ntt_bfly_pkg::*;
#(
  parameter int unsigned Q     = 3329,
  parameter int unsigned W     = 12,
  parameter int unsigned LOG_R = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  phaseStrobes_t strobes,
  input  logic [W-1:0]  uIn,
  input  logic [W-1:0]  vIn,
  input  logic [W-1:0]  wIn,
  output logic [W-1:0]  xOut,
  output logic [W-1:0]  yOut
);

  localparam logic [31:0] QNEG = negInvModPow2(Q, LOG_R);

  // Phase 1: operand buffer
  logic [W-1:0] uBuf, vBuf, wBuf;
  // Phase 2: reduced product and carried u
  logic [2*W-1:0] prodBuf;
  logic [W-1:0]   tRed;
  logic [W-1:0]   uMul, tMul;
  // Phase 3: results
  logic [W-1:0]   sumNext, difNext;

  always_ff @(posedge clk) begin
    if (strobes.ldBuf) begin
      uBuf <= uIn;
      vBuf <= vIn;
      wBuf <= wIn;
    end
  end

  assign prodBuf = vBuf * wBuf;

  mont_reduce #(
    .Q(Q), .W(W), .LOG_R(LOG_R), .QNEG(QNEG)
  ) uRed (
    .prodIn(prodBuf),
    .redOut(tRed)
  );

  always_ff @(posedge clk) begin
    if (strobes.ldMul) begin
      uMul <= uBuf;
      tMul <= tRed;
    end
  end

  mod_addsub #(
    .Q(Q), .W(W)
  ) uAddSub (
    .aIn(uMul),
    .bIn(tMul),
    .sumOut(sumNext),
    .difOut(difNext)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      xOut <= '0;
      yOut <= '0;
    end else if (strobes.ldSum) begin
      xOut <= sumNext;
      yOut <= difNext;
    end
  end

endmodule

// File: rtl/ntt_butterfly.sv
module ntt_butterfly
  import ntt_bfly_pkg::*;
#(
  parameter int unsigned Q       = 3329,
  parameter int unsigned LOG_R   = 16,
  parameter int unsigned COEFF_W = $clog2(Q)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               validIn,
  input  logic [COEFF_W-1:0] uIn,
  input  logic [COEFF_W-1:0] vIn,
  input  logic [COEFF_W-1:0] wIn,
  output logic               validOut,
  output logic [COEFF_W-1:0] xOut,
  output logic [COEFF_W-1:0] yOut
);

  phaseStrobes_t strobes;

  bfly_ctrl #(
    .DEPTH(PIPE_DEPTH)
  ) uCtrl (
    .clk(clk),
    .rst(rst),
    .validIn(validIn),
    .strobes(strobes),
    .validOut(validOut)
  );

  bfly_datapath #(
    .Q(Q), .W(COEFF_W), .LOG_R(LOG_R)
  ) uPath (
    .clk(clk),
    .rst(rst),
    .strobes(strobes),
    .uIn(uIn),
    .vIn(vIn),
    .wIn(wIn),
    .xOut(xOut),
    .yOut(yOut)
  );

endmodule

// File: rtl/bfly_checker.sv
module bfly_checker #(
  parameter int unsigned Q = 3329,
  parameter int unsigned W = 12
) (
  input logic         clk,
  input logic         rst,
  input logic         validIn,
  input logic [W-1:0] uIn,
  input logic         validOut,
  input logic [W-1:0] xOut,
  input logic [W-1:0] yOut
);

  logic [1:0] sinceRst;
  logic       warm;

  always_ff @(posedge clk) begin
    if (rst) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  assign warm = (sinceRst == 2'd3);

  // R3
  a_r3_in_range: assert property (@(posedge clk) disable iff (rst)
    validOut |-> (int'(xOut) < int'(Q)) && (int'(yOut) < int'(Q)));

  // R4
  a_r4_latency: assert property (@(posedge clk) disable iff (rst)
    warm |-> (validOut == $past(validIn, 3)));

  // R1 and R2: x + y must equal 2u mod q for the beat that entered three cycles ago
  a_r2_pair_sum: assert property (@(posedge clk) disable iff (rst)
    (warm && validOut) |->
      (((int'(xOut) + int'(yOut)) % int'(Q)) == ((2 * int'($past(uIn, 3))) % int'(Q))));

  // R6
  a_r6_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!validOut && xOut == '0 && yOut == '0));

  // R8
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!validOut && !$past(rst)) |-> ($stable(xOut) && $stable(yOut)));

endmodule

bind ntt_butterfly bfly_checker #(.Q(Q), .W(COEFF_W)) uChk (
  .clk(clk),
  .rst(rst),
  .validIn(validIn),
  .uIn(uIn),
  .validOut(validOut),
  .xOut(xOut),
  .yOut(yOut)
);

// File: tb/tb_ntt_butterfly.sv
`timescale 1ns/1ps
module tb_ntt_butterfly;

  localparam int Q = 3329;
  localparam int NTAB = 12;
  localparam int MAXS = 320;

  // {u, v, w(plain), x expected, y expected}
  localparam int TAB [NTAB][5] = '{
    '{0,    0,    0,    0,    0   },
    '{1,    1,    1,    2,    0   },
    '{0,    1,    1,    1,    3328},
    '{3328, 1,    1,    0,    3327},
    '{3328, 3328, 3328, 0,    3327},
    '{5,    3328, 1,    4,    6   },
    '{100,  2,    3,    106,  94  },
    '{0,    3328, 2,    3327, 2   },
    '{1664, 1,    1665, 0,    3328},
    '{1000, 17,   17,   1289, 711 },
    '{3000, 2000, 0,    3000, 3000},
    '{2,    1,    3328, 1,    3   }
  };

  logic clk = 0;
  logic rst = 1;
  logic validIn = 0;
  logic [11:0] uIn = 0, vIn = 0, wIn = 0;
  logic validOut;
  logic [11:0] xOut, yOut;

  always #2.5 clk = ~clk;

  ntt_butterfly dut (
    .clk(clk), .rst(rst), .validIn(validIn),
    .uIn(uIn), .vIn(vIn), .wIn(wIn),
    .validOut(validOut), .xOut(xOut), .yOut(yOut)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int sU [MAXS], sV [MAXS], sW [MAXS], sX [MAXS], sY [MAXS];
  bit sLive [MAXS];
  int lastX = 0, lastY = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int toMont(input int w);
    return int'((longint'(w) * 65536) % Q);
  endfunction

  function automatic int refSum(input int u, input int v, input int w);
    return int'((longint'(u) + longint'(v) * w) % Q);
  endfunction

  function automatic int refDif(input int u, input int v, input int w);
    return int'(((longint'(u) - (longint'(v) * w) % Q) % Q + Q) % Q);
  endfunction

  // Stream n slots, one per cycle, and check each slot three cycles later.
  task automatic runStream(input int n, input string req);
    for (int c = 0; c < n + 3; c++) begin
      @(negedge clk);
      if (c >= 3) begin
        check(validOut == sLive[c-3], "R4", {req, " valid alignment"}, int'(validOut), int'(sLive[c-3]));
        if (sLive[c-3]) begin
          check(int'(xOut) == sX[c-3], "R1", {req, " sum"}, int'(xOut), sX[c-3]);
          check(int'(yOut) == sY[c-3], "R2", {req, " difference"}, int'(yOut), sY[c-3]);
          check(int'(xOut) < Q && int'(yOut) < Q, "R3", {req, " range"}, int'(xOut), Q - 1);
          lastX = sX[c-3];
          lastY = sY[c-3];
        end
      end
      if (c < n) begin
        validIn = sLive[c];
        uIn = 12'(sU[c]);
        vIn = 12'(sV[c]);
        wIn = 12'(toMont(sW[c]));
      end else begin
        validIn = 0;
      end
    end
  endtask

  initial begin
    int seed;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(validOut == 0, "R6", "reset valid", int'(validOut), 0);
    check(xOut == 0 && yOut == 0, "R6", "reset data", int'(xOut) + int'(yOut), 0);

    // Table of hand-worked edge beats, back to back (R7)
    for (int i = 0; i < NTAB; i++) begin
      sU[i] = TAB[i][0]; sV[i] = TAB[i][1]; sW[i] = TAB[i][2];
      sX[i] = TAB[i][3]; sY[i] = TAB[i][4]; sLive[i] = 1;
    end
    runStream(NTAB, "R7 table");

    // Hold while idle (R8)
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(validOut == 0, "R8", "idle valid", int'(validOut), 0);
      check(int'(xOut) == lastX && int'(yOut) == lastY, "R8", "held sum", int'(xOut), lastX);
    end

    // Random beats with bubbles (R5), edge values mixed in
    seed = 7;
    for (int i = 0; i < 300; i++) begin
      int r = int'($urandom(seed + i) % 8);
      sU[i] = (r == 0) ? 0 : (r == 1) ? Q - 1 : int'($urandom % Q);
      sV[i] = (r == 2) ? Q - 1 : int'($urandom % Q);
      sW[i] = (r == 3) ? Q - 1 : (r == 4) ? 0 : int'($urandom % Q);
      sLive[i] = (i % 11 != 5) && (i % 17 != 3);
      sX[i] = refSum(sU[i], sV[i], sW[i]);
      sY[i] = refDif(sU[i], sV[i], sW[i]);
    end
    runStream(300, "R5 random");

    // Reset in the middle of a stream (R6)
    @(negedge clk);
    validIn = 1; uIn = 12'd10; vIn = 12'd20; wIn = 12'(toMont(30));
    @(negedge clk);
    uIn = 12'd11;
    @(negedge clk);
    validIn = 0;
    rst = 1;
    @(negedge clk);
    rst = 0;
    check(validOut == 0, "R6", "valid after mid reset", int'(validOut), 0);
    check(xOut == 0 && yOut == 0, "R6", "data after mid reset", int'(xOut), 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(validOut == 0, "R6", "flushed beat appeared", int'(validOut), 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule